// File: doc/BRIEF.md
# Serial Audio Receive Channel Buffer

This block takes one receive audio time-slot line, presented as a serial data bit with a bit-valid strobe, and collects the bits in a 32-bit shift register. At a chosen moment it copies the whole register into a parallel read register. Both a DSP-side reader and a host-side reader share that register. Each copy sets a buffer-full flag that can raise an interrupt. Because the reader has a whole word period to respond, it does not need to keep pace with single bits.

There are two load triggers, chosen by a mode bit. In count mode, a copy happens as soon as a programmed number of bits (1 to 32) has arrived. That number is meant to be a whole number of time slots. In frame mode, a copy happens on every frame sync pulse. In that case the useful bits are the ones received since the previous pulse, and they end up right-aligned. A frame-sync flag can drive the interrupt in place of buffer-full. Reception never pauses while the reader collects a word.

Top module: `audio_rx_chan`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), rd_data is 0 and buf_full, overrun, fs_flag and irq are all 0.
- R2: When en is 1 and sbit_vld is 1, sdata enters bit 0 of the shift register and older bits move one place toward bit 31. A load copies into rd_data the full 32-bit register value that includes the bit arriving in that cycle.
- R3: In count mode (load_mode = 0), rd_data loads on the edge that accepts the load_bits-th valid bit counted since the previous load. After each load the count starts again from zero. Cycles with sbit_vld = 0 neither shift nor count.
- R4: In frame mode (load_mode = 1), rd_data loads on every edge where fsync is 1 (including a bit arriving in the same cycle), and reaching the bit count causes no load.
- R5: Every load sets buf_full. A pulse on rd_dsp, rd_host or clr_full clears it. A load in the same cycle as a clear leaves buf_full set.
- R6: A load while buf_full is 1 and no clear is present in that cycle sets overrun. Overrun stays set until clr_full.
- R7: While en is 1, each fsync pulse sets fs_flag in either mode. A pulse on clr_fs clears it, and a set in the same cycle wins.
- R8: irq is 0 while irq_en is 0. Otherwise irq equals buf_full when irq_sel = 0 and fs_flag when irq_sel = 1.
- R9: While en is 0, the shift register holds, rd_data does not change, no flag is set, and the bit count is cleared. After re-enabling, a count-mode load therefore needs a full load_bits bits.
- R10: In count mode an fsync pulse causes no load and does not restart the bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Channel enable |
| load_mode | input | 1 | 0 = load after a bit count, 1 = load on frame sync |
| load_bits | input | 6 | Bits per load in count mode, 1..32 |
| sdata | input | 1 | Serial receive bit |
| sbit_vld | input | 1 | sdata is valid this cycle |
| fsync | input | 1 | Frame sync pulse, one cycle |
| rd_dsp | input | 1 | DSP-side read of rd_data, clears buf_full |
| rd_host | input | 1 | Host-side read of rd_data, clears buf_full |
| clr_full | input | 1 | Write-one-to-clear of buf_full and overrun |
| clr_fs | input | 1 | Write-one-to-clear of fs_flag |
| irq_en | input | 1 | Interrupt mask, 1 = enabled |
| irq_sel | input | 1 | Interrupt source: 0 = buf_full, 1 = fs_flag |
| rd_data | output | 32 | Parallel read register |
| buf_full | output | 1 | New word loaded and not yet read |
| overrun | output | 1 | A word was overwritten before it was read |
| fs_flag | output | 1 | Frame sync seen |
| irq | output | 1 | Masked interrupt |

## Verification
The assertions rely on the following input conditions:
- load_bits stays in 1..32 and changes only when the bit count is zero, which is directly after a load or while the channel is disabled.
- fsync is a single-cycle pulse.

On those conditions, the count-mode bit counter never goes above the word width, and in count mode a load happens only on a valid bit.

The stimulus respects these conditions. It changes load_bits only after a word has been collected, and it switches modes only just after a load or while the channel is off. Every fsync and every read or clear strobe it drives lasts exactly one clock.

// File: rtl/audio_rx_pkg.sv
// Package: shared types for the serial audio receive channel.
// Assumes nothing beyond the standard language.
package audio_rx_pkg;
    typedef enum logic {
        LOAD_ON_COUNT = 1'b0,
        LOAD_ON_FRAME = 1'b1
    } load_mode_e;
endpackage

// File: rtl/audio_rx_shifter.sv
// Module: serial-to-parallel shifter with a saturating bit counter.
// New bits enter at bit 0. The counter clears on a load or while disabled.
// Assumes: limit stays in 1..DW and changes only while the count is zero.
module audio_rx_shifter #(
    parameter int DW = 32,
    parameter int CW = $clog2(DW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          bit_in,
    input  logic          bit_vld,
    input  logic          load,
    input  logic [CW-1:0] limit,
    output logic [DW-1:0] shift_nxt,
    output logic          cnt_hit
);
    logic [DW-1:0] shift_q;
    logic [CW-1:0] cnt_q;
    logic          take;

    // Purpose: accept a bit only while enabled.
    assign take = en && bit_vld;

    // Purpose: the value the register holds after this cycle's bit.
    always_comb begin
        shift_nxt = take ? {shift_q[DW-2:0], bit_in} : shift_q;
    end

    // Purpose: flag the bit that completes the programmed count.
    assign cnt_hit = take && ((cnt_q + CW'(1)) >= limit);

    // Purpose: register the shifted value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shift_q <= '0;
        else
            shift_q <= shift_nxt;
    end

    // Purpose: count accepted bits since the last load, saturating at DW.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || load)
            cnt_q <= '0;
        else if (bit_vld && (cnt_q != CW'(DW)))
            cnt_q <= cnt_q + CW'(1);
    end

    assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DW));

    assert_hold_no_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(shift_q));
endmodule

// File: rtl/audio_rx_loadsel.sv
// Module: chooses when the read register loads.
// Count mode loads on the completing bit. Frame mode loads on fsync.
// Assumes: fsync is a single-cycle pulse.
module audio_rx_loadsel
    import audio_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  load_mode_e mode,
    input  logic       cnt_hit,
    input  logic       bit_vld,
    input  logic       fsync,
    output logic       load
);
    // Purpose: pick the load trigger for the selected mode.
    always_comb begin
        load = 1'b0;
        if (en) begin
            case (mode)
                LOAD_ON_COUNT: load = cnt_hit;
                LOAD_ON_FRAME: load = fsync;
                default:       load = 1'b0;
            endcase
        end
    end

    assert_count_needs_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LOAD_ON_COUNT && !bit_vld) |-> !load);

    assert_frame_needs_sync_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LOAD_ON_FRAME && !fsync) |-> !load);
endmodule

// File: rtl/audio_rx_status.sv
// Module: buffer-full, overrun and frame-sync flags plus the masked interrupt.
// In each flag, a set in the same cycle as a clear wins.
// Assumes: the read and clear strobes last one cycle each.
module audio_rx_status (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic fs_evt,
    input  logic rd_any,
    input  logic clr_full,
    input  logic clr_fs,
    input  logic irq_en,
    input  logic irq_sel,
    output logic buf_full,
    output logic overrun,
    output logic fs_flag,
    output logic irq
);
    logic clr_any;

    // Purpose: any action that counts as collecting the word.
    assign clr_any = rd_any || clr_full;

    // Purpose: buffer-full flag.
    always_ff @(posedge clk) begin
        if (!rst_n)
            buf_full <= 1'b0;
        else if (load)
            buf_full <= 1'b1;
        else if (clr_any)
            buf_full <= 1'b0;
    end

    // Purpose: sticky overrun flag, cleared only by the explicit clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            overrun <= 1'b0;
        else if (load && buf_full && !clr_any)
            overrun <= 1'b1;
        else if (clr_full)
            overrun <= 1'b0;
    end

    // Purpose: frame-sync flag.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fs_flag <= 1'b0;
        else if (fs_evt)
            fs_flag <= 1'b1;
        else if (clr_fs)
            fs_flag <= 1'b0;
    end

    // Purpose: masked interrupt from the selected flag.
    assign irq = irq_en && (irq_sel ? fs_flag : buf_full);

    assert_full_on_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> buf_full);

    assert_overrun_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (load && buf_full && !clr_any) |=> overrun);

    assert_overrun_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !clr_full) |=> overrun);

    assert_fs_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fs_evt |=> fs_flag);
endmodule

// File: rtl/audio_rx_chan.sv
// Module: top of the serial audio receive channel buffer.
// It ties the shifter, the load selector and the status flags to the read register.
// Assumes: load_bits stays in 1..DW, and fsync is a one-cycle pulse.
module audio_rx_chan
    import audio_rx_pkg::*;
#(
    parameter int DW = 32,
    parameter int CW = $clog2(DW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          load_mode,
    input  logic [CW-1:0] load_bits,
    input  logic          sdata,
    input  logic          sbit_vld,
    input  logic          fsync,
    input  logic          rd_dsp,
    input  logic          rd_host,
    input  logic          clr_full,
    input  logic          clr_fs,
    input  logic          irq_en,
    input  logic          irq_sel,
    output logic [DW-1:0] rd_data,
    output logic          buf_full,
    output logic          overrun,
    output logic          fs_flag,
    output logic          irq
);
    logic [DW-1:0] shift_nxt;
    logic          cnt_hit;
    logic          load;
    load_mode_e    mode;

    // Purpose: interpret the mode pin as the typed mode.
    assign mode = load_mode_e'(load_mode);

    audio_rx_shifter #(.DW(DW), .CW(CW)) shifter_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .bit_in    (sdata),
        .bit_vld   (sbit_vld),
        .load      (load),
        .limit     (load_bits),
        .shift_nxt (shift_nxt),
        .cnt_hit   (cnt_hit)
    );

    audio_rx_loadsel loadsel_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .mode    (mode),
        .cnt_hit (cnt_hit),
        .bit_vld (sbit_vld),
        .fsync   (fsync),
        .load    (load)
    );

    audio_rx_status status_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .fs_evt   (en && fsync),
        .rd_any   (rd_dsp || rd_host),
        .clr_full (clr_full),
        .clr_fs   (clr_fs),
        .irq_en   (irq_en),
        .irq_sel  (irq_sel),
        .buf_full (buf_full),
        .overrun  (overrun),
        .fs_flag  (fs_flag),
        .irq      (irq)
    );

    // Purpose: the read register shared by both readers.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (load)
            rd_data <= shift_nxt;
    end

    assert_hold_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(rd_data));

    assert_no_flag_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !buf_full) |=> !buf_full);

    assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);
endmodule

// File: tb/audio_rx_chan_tb_top.sv
`timescale 1ns/1ps
module audio_rx_chan_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        load_mode = 1'b0;
    logic [5:0]  load_bits = 6'd8;
    logic        sdata = 1'b0;
    logic        sbit_vld = 1'b0;
    logic        fsync = 1'b0;
    logic        rd_dsp = 1'b0;
    logic        rd_host = 1'b0;
    logic        clr_full = 1'b0;
    logic        clr_fs = 1'b0;
    logic        irq_en = 1'b0;
    logic        irq_sel = 1'b0;
    logic [31:0] rd_data;
    logic        buf_full;
    logic        overrun;
    logic        fs_flag;
    logic        irq;

    int          n_vec = 0;
    int          n_bad = 0;
    logic [31:0] shift_m = '0;
    logic [31:0] rd_keep;

    always #2.5 clk = ~clk;

    audio_rx_chan dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .load_mode(load_mode),
        .load_bits(load_bits), .sdata(sdata), .sbit_vld(sbit_vld),
        .fsync(fsync), .rd_dsp(rd_dsp), .rd_host(rd_host),
        .clr_full(clr_full), .clr_fs(clr_fs), .irq_en(irq_en),
        .irq_sel(irq_sel), .rd_data(rd_data), .buf_full(buf_full),
        .overrun(overrun), .fs_flag(fs_flag), .irq(irq)
    );

    // Stimulus table: bit count in the upper 6 bits, pattern (sent MSB first) below.
    localparam logic [37:0] VEC [6] = '{
        {6'd8,  32'h0000_00A5},
        {6'd1,  32'h0000_0001},
        {6'd32, 32'hDEAD_BEEF},
        {6'd16, 32'h0000_1234},
        {6'd4,  32'h0000_0009},
        {6'd24, 32'h00C3_5A7E}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic send_bit(input logic b, input logic fs, input logic hr);
        sdata = b; sbit_vld = 1'b1; fsync = fs; rd_host = hr;
        tick();
        sbit_vld = 1'b0; fsync = 1'b0; rd_host = 1'b0;
        if (en) shift_m = {shift_m[30:0], b};
    endtask

    task automatic send_n(input int n, input logic [31:0] pat);
        for (int k = n - 1; k >= 0; k--) send_bit(pat[k], 1'b0, 1'b0);
    endtask

    task automatic pulse_rd_dsp();  rd_dsp = 1'b1;  tick(); rd_dsp = 1'b0;  endtask
    task automatic pulse_clr_full(); clr_full = 1'b1; tick(); clr_full = 1'b0; endtask
    task automatic pulse_clr_fs();  clr_fs = 1'b1;  tick(); clr_fs = 1'b0;  endtask
    task automatic pulse_fsync();   fsync = 1'b1;   tick(); fsync = 1'b0;   endtask

    initial begin : watchdog
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        tick(); tick(); tick();
        // R1 reset state
        check("R1 rd_data", rd_data, 32'h0);
        check("R1 flags", {28'h0, buf_full, overrun, fs_flag, irq}, 32'h0);
        rst_n = 1'b1;
        en = 1'b1;
        tick();

        // R2 R3 R5: table walk in count mode
        for (int v = 0; v < 6; v++) begin
            logic [5:0]  nb;
            logic [31:0] pat;
            nb = VEC[v][37:32];
            pat = VEC[v][31:0];
            load_bits = nb;
            rd_keep = rd_data;
            if (nb > 1) begin
                send_n(nb - 1, pat >> 1);
                check("R3 no early load", {31'h0, buf_full}, 32'h0);
                check("R3 rd held", rd_data, rd_keep);
            end
            send_bit(pat[0], 1'b0, 1'b0);
            check("R2 loaded word", rd_data, shift_m);
            check("R5 full on load", {31'h0, buf_full}, 32'h1);
            pulse_rd_dsp();
            check("R5 cleared by dsp read", {31'h0, buf_full}, 32'h0);
        end

        // R3: idle gaps neither shift nor count
        load_bits = 6'd8;
        send_n(3, 32'h5);
        repeat (5) tick();
        check("R3 gap no load", {31'h0, buf_full}, 32'h0);
        send_n(5, 32'h16);
        check("R3 word after gap", rd_data, shift_m);
        check("R3 full after gap", {31'h0, buf_full}, 32'h1);
        rd_host = 1'b1; tick(); rd_host = 1'b0;
        check("R5 cleared by host read", {31'h0, buf_full}, 32'h0);

        // R10: fsync in count mode neither loads nor restarts the count
        rd_keep = rd_data;
        send_n(3, 32'h3);
        send_bit(1'b1, 1'b1, 1'b0);
        check("R10 no load on fsync", {31'h0, buf_full}, 32'h0);
        check("R10 rd held", rd_data, rd_keep);
        check("R7 fs_flag set", {31'h0, fs_flag}, 32'h1);
        send_n(4, 32'hA);
        check("R10 load at count", rd_data, shift_m);
        pulse_clr_fs();
        check("R7 fs_flag cleared", {31'h0, fs_flag}, 32'h0);

        // R8: interrupt masking and source select (buf_full is 1 here)
        check("R8 masked", {31'h0, irq}, 32'h0);
        irq_en = 1'b1; tick();
        check("R8 full source", {31'h0, irq}, 32'h1);
        irq_sel = 1'b1; tick();
        check("R8 fs source idle", {31'h0, irq}, 32'h0);
        pulse_fsync();
        check("R8 fs source set", {31'h0, irq}, 32'h1);
        fsync = 1'b1; clr_fs = 1'b1; tick(); fsync = 1'b0; clr_fs = 1'b0;
        check("R7 set wins over clear", {31'h0, fs_flag}, 32'h1);
        pulse_clr_fs();
        check("R8 fs source cleared", {31'h0, irq}, 32'h0);
        irq_en = 1'b0; irq_sel = 1'b0;
        pulse_rd_dsp();

        // R6: overrun
        send_n(8, 32'h11);
        send_n(8, 32'h22);
        check("R6 overrun set", {31'h0, overrun}, 32'h1);
        check("R6 latest word", rd_data, shift_m);
        pulse_rd_dsp();
        check("R6 overrun sticky on read", {31'h0, overrun}, 32'h1);
        pulse_clr_full();
        check("R6 overrun cleared", {30'h0, overrun, buf_full}, 32'h0);

        // R5: load with a read in the same cycle keeps full, no overrun
        send_n(8, 32'h33);
        send_n(7, 32'h22);
        send_bit(1'b0, 1'b0, 1'b1);
        check("R5 set wins", {30'h0, buf_full, overrun}, 32'h2);
        check("R5 word", rd_data, shift_m);
        pulse_clr_full();

        // R4: frame mode
        load_mode = 1'b1; load_bits = 6'd4;
        send_n(6, 32'h2D);
        check("R4 count ignored", {31'h0, buf_full}, 32'h0);
        pulse_fsync();
        check("R4 load on fsync", rd_data, shift_m);
        check("R4 full", {31'h0, buf_full}, 32'h1);
        pulse_clr_full();
        send_n(11, 32'h5A3);
        send_bit(1'b1, 1'b1, 1'b0);
        check("R4 bit with fsync", rd_data, shift_m);
        pulse_clr_full();
        pulse_clr_fs();

        // R9: disable holds state and clears the count
        load_mode = 1'b0; load_bits = 6'd8;
        send_n(3, 32'h7);
        en = 1'b0;
        rd_keep = rd_data;
        send_n(5, 32'h1F);
        pulse_fsync();
        check("R9 rd held", rd_data, rd_keep);
        check("R9 no flags", {30'h0, buf_full, fs_flag}, 32'h0);
        en = 1'b1;
        send_n(7, 32'h4C);
        check("R9 count restarted", {31'h0, buf_full}, 32'h0);
        send_bit(1'b1, 1'b0, 1'b0);
        check("R9 word after enable", rd_data, shift_m);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule